// File: doc/BRIEF.md
# Instruction Length and PC Sequencer

This fetch-side unit sits between an instruction halfword stream and the decode stage of a core that mixes 16-bit compressed and 32-bit instructions. It accepts one halfword per cycle over a valid/ready handshake. It works out the length of each instruction from the two low bits of its first halfword. For a 32-bit instruction it joins two halfwords into one word. It presents each finished instruction for one cycle, together with its PC, the successor PC and a compressed flag. For compressed encodings it also gives the two short register selectors already expanded to full register numbers.

Jumps are reported back to the sequencer and always refer to the instruction most recently presented. The unit checks the alignment of the target and redirects the fetch PC. It produces the link write for the destination register, or it raises a misaligned-target exception that carries the PC of the jump. A compressed-enable input selects whether 16-bit encodings are legal and whether targets only need halfword alignment.

Top module: `ilen_pc_seq`

## Requirements
- R1: A first halfword whose bits 1:0 are not 2'b11 is a 16-bit instruction. In the cycle after it is accepted, insn_valid_o is 1, insn_c_o is 1, insn_o holds the halfword zero-extended, insn_pc_o is its PC and succ_pc_o is that PC plus 2.
- R2: A first halfword whose bits 1:0 are 2'b11 starts a 32-bit instruction. Nothing is presented until a second halfword is accepted. Then insn_o is {second, first}, insn_c_o is 0, insn_pc_o is the PC of the first halfword and succ_pc_o is that PC plus 4.
- R3: A 16-bit instruction accepted while c_en_i is 0 sets illegal_o together with its insn_valid_o. 32-bit instructions never set illegal_o.
- R4: A jump sets misalign_o only when c_en_i is 0 and target bits 1:0 are nonzero. With c_en_i at 1, bit 1 may be set. Bit 0 of the target is always treated as 0.
- R5: On a misaligned target, badaddr_o holds the PC of the most recent instruction, and the fetch PC is not redirected.
- R6: A legal jump with a nonzero destination sets link_we_o, link_rd_o and link_data_o, where link_data_o is the successor PC of the most recent instruction. A legal jump with destination 0 writes nothing, and neither does a misaligned jump.
- R7: crs1_o is 8 plus insn_o bits 9:7, and crs2_o is 8 plus insn_o bits 4:2.
- R8: After reset, insn_valid_o, illegal_o, misalign_o and link_we_o are 0, hw_ready_o is 1, and the first instruction takes its PC from RESET_PC.
- R9: hw_ready_o is 0 in any cycle where jump_valid_i is 1, so a halfword offered in that cycle is not consumed. A jump also drops a half-collected 32-bit instruction, and fetch resumes at the target.
- R10: insn_valid_o, illegal_o, misalign_o and link_we_o each last one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| c_en_i | input | 1 | Compressed instructions enabled |
| hw_valid_i | input | 1 | Halfword offered |
| hw_data_i | input | 16 | Halfword data |
| hw_ready_o | output | 1 | Halfword can be taken |
| jump_valid_i | input | 1 | Jump taken by the most recent instruction |
| jump_target_i | input | XLEN | Jump target address |
| jump_rd_i | input | 5 | Link destination register |
| insn_valid_o | output | 1 | Instruction presented this cycle |
| insn_o | output | 32 | Instruction word |
| insn_c_o | output | 1 | Instruction is 16-bit |
| insn_pc_o | output | XLEN | PC of the instruction |
| succ_pc_o | output | XLEN | Successor PC |
| crs1_o | output | 5 | Expanded selector from bits 9:7 |
| crs2_o | output | 5 | Expanded selector from bits 4:2 |
| illegal_o | output | 1 | Illegal compressed instruction |
| misalign_o | output | 1 | Misaligned jump target |
| badaddr_o | output | XLEN | PC of the faulting jump |
| link_we_o | output | 1 | Link register write |
| link_rd_o | output | 5 | Link destination |
| link_data_o | output | XLEN | Link value |

## Verification
Each instruction result appears one clock edge after the halfword that completes it is accepted. Exception and link outputs appear one edge after the jump cycle. hw_ready_o is combinational in the cycle the jump is driven. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge, where these registered results have settled. It samples again one cycle later to confirm that the pulses have dropped. The ready check is made shortly after the falling edge, in the same cycle as the jump.

// File: rtl/ilseq_pkg.sv
package ilseq_pkg;
  localparam int unsigned HW_W   = 16;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned CREG_W = 3;

  function automatic logic is_short(input logic [HW_W-1:0] hw);
    return hw[1:0] != 2'b11;
  endfunction

  function automatic logic [REG_AW-1:0] creg_expand(input logic [CREG_W-1:0] f);
    return REG_AW'(8) + REG_AW'(f);
  endfunction
endpackage

// File: rtl/ilseq_assemble.sv
module ilseq_assemble
  import ilseq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic                flush_i,
  input  logic [HW_W-1:0]     hw_i,
  output logic                issue_o,
  output logic                issue_c_o,
  output logic [INSN_W-1:0]   word_o
);
  logic            wait_hi_q;
  logic [HW_W-1:0] low_q;

  always_comb begin
    issue_o   = 1'b0;
    issue_c_o = 1'b0;
    word_o    = '0;
    if (accept_i) begin
      if (wait_hi_q) begin
        issue_o = 1'b1;
        word_o  = {hw_i, low_q};
      end else if (is_short(hw_i)) begin
        issue_o   = 1'b1;
        issue_c_o = 1'b1;
        word_o    = {{(INSN_W-HW_W){1'b0}}, hw_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_hi_q <= 1'b0;
      low_q     <= '0;
    end else if (flush_i) begin
      wait_hi_q <= 1'b0;
    end else if (accept_i) begin
      if (wait_hi_q) begin
        wait_hi_q <= 1'b0;
      end else if (!is_short(hw_i)) begin
        wait_hi_q <= 1'b1;
        low_q     <= hw_i;
      end
    end
  end

  // R2: a full word is only emitted when a first half was held
  p_two_halves_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && !issue_c_o) |-> wait_hi_q);
endmodule

// File: rtl/ilseq_pc.sv
module ilseq_pc #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic            issue_c_i,
  input  logic            redirect_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] succ_o
);
  logic [XLEN-1:0] pc_q;

  assign pc_o   = pc_q;
  assign succ_o = pc_q + (issue_c_i ? XLEN'(2) : XLEN'(4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= RESET_PC;
    else if (redirect_i) pc_q <= target_i;
    else if (issue_i)    pc_q <= succ_o;
  end

  p_step_short_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && issue_c_i && !redirect_i) |=> pc_q == $past(pc_q) + XLEN'(2));
  p_step_long_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !issue_c_i && !redirect_i) |=> pc_q == $past(pc_q) + XLEN'(4));
endmodule

// File: rtl/ilseq_jump.sv
module ilseq_jump
  import ilseq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              c_en_i,
  input  logic              jump_valid_i,
  input  logic [XLEN-1:0]   jump_target_i,
  input  logic [REG_AW-1:0] jump_rd_i,
  input  logic [XLEN-1:0]   last_pc_i,
  input  logic [XLEN-1:0]   last_succ_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic              misalign_o,
  output logic [XLEN-1:0]   badaddr_o,
  output logic              link_we_o,
  output logic [REG_AW-1:0] link_rd_o,
  output logic [XLEN-1:0]   link_data_o
);
  logic bad_align;

  assign bad_align  = !c_en_i && (jump_target_i[1:0] != 2'b00);
  assign redirect_o = jump_valid_i && !bad_align;
  assign target_o   = {jump_target_i[XLEN-1:1], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misalign_o  <= 1'b0;
      badaddr_o   <= '0;
      link_we_o   <= 1'b0;
      link_rd_o   <= '0;
      link_data_o <= '0;
    end else begin
      misalign_o <= jump_valid_i && bad_align;
      link_we_o  <= redirect_o && (jump_rd_i != '0);
      if (jump_valid_i && bad_align) badaddr_o <= last_pc_i;
      if (redirect_o && (jump_rd_i != '0)) begin
        link_rd_o   <= jump_rd_i;
        link_data_o <= last_succ_i;
      end
    end
  end

  p_misalign_cen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !$past(c_en_i));
  p_misalign_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> $past(jump_valid_i));
  p_no_link_on_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> !misalign_o && link_rd_o != '0);
endmodule

// File: rtl/ilen_pc_seq.sv
module ilen_pc_seq
  import ilseq_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h100)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              c_en_i,
  input  logic              hw_valid_i,
  input  logic [HW_W-1:0]   hw_data_i,
  output logic              hw_ready_o,
  input  logic              jump_valid_i,
  input  logic [XLEN-1:0]   jump_target_i,
  input  logic [REG_AW-1:0] jump_rd_i,
  output logic              insn_valid_o,
  output logic [INSN_W-1:0] insn_o,
  output logic              insn_c_o,
  output logic [XLEN-1:0]   insn_pc_o,
  output logic [XLEN-1:0]   succ_pc_o,
  output logic [REG_AW-1:0] crs1_o,
  output logic [REG_AW-1:0] crs2_o,
  output logic              illegal_o,
  output logic              misalign_o,
  output logic [XLEN-1:0]   badaddr_o,
  output logic              link_we_o,
  output logic [REG_AW-1:0] link_rd_o,
  output logic [XLEN-1:0]   link_data_o
);
  logic              accept, issue, issue_c, redirect;
  logic [INSN_W-1:0] word;
  logic [XLEN-1:0]   cur_pc, cur_succ, target;

  assign hw_ready_o = !jump_valid_i;
  assign accept     = hw_valid_i && hw_ready_o;

  ilseq_assemble i_assemble (
    .clk_i, .rst_ni,
    .accept_i  (accept),
    .flush_i   (jump_valid_i),
    .hw_i      (hw_data_i),
    .issue_o   (issue),
    .issue_c_o (issue_c),
    .word_o    (word)
  );

  ilseq_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC)) i_pc (
    .clk_i, .rst_ni,
    .issue_i    (issue),
    .issue_c_i  (issue_c),
    .redirect_i (redirect),
    .target_i   (target),
    .pc_o       (cur_pc),
    .succ_o     (cur_succ)
  );

  ilseq_jump #(.XLEN(XLEN)) i_jump (
    .clk_i, .rst_ni,
    .c_en_i, .jump_valid_i, .jump_target_i, .jump_rd_i,
    .last_pc_i   (insn_pc_o),
    .last_succ_i (succ_pc_o),
    .redirect_o  (redirect),
    .target_o    (target),
    .misalign_o, .badaddr_o, .link_we_o, .link_rd_o, .link_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insn_valid_o <= 1'b0;
      insn_o       <= '0;
      insn_c_o     <= 1'b0;
      insn_pc_o    <= RESET_PC;
      succ_pc_o    <= RESET_PC;
      illegal_o    <= 1'b0;
    end else begin
      insn_valid_o <= issue;
      illegal_o    <= issue && issue_c && !c_en_i;
      if (issue) begin
        insn_o    <= word;
        insn_c_o  <= issue_c;
        insn_pc_o <= cur_pc;
        succ_pc_o <= cur_succ;
      end
    end
  end

  // short register selectors, one per field position
  localparam int unsigned NSEL = 2;
  localparam int unsigned SEL_LSB [NSEL] = '{7, 2};
  logic [REG_AW-1:0] sel [NSEL];
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel[g] = creg_expand(insn_o[SEL_LSB[g] +: CREG_W]);
  end
  assign crs1_o = sel[0];
  assign crs2_o = sel[1];

  p_illegal_short_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> insn_valid_o && insn_c_o);
  p_no_take_on_jump_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(jump_valid_i) |-> !insn_valid_o);
endmodule

// File: tb/test_ilen_pc_seq.sv
module test_ilen_pc_seq;
  localparam int XLEN = 32;
  localparam logic [31:0] RPC = 32'h100;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        c_en = 1'b1, hv = 1'b0, jv = 1'b0;
  logic [15:0] hd = '0;
  logic [31:0] jt = '0;
  logic [4:0]  jrd = '0;
  logic        hr, iv, ic, ill, mis, lwe;
  logic [31:0] insn, ipc, spc, bad, ldat;
  logic [4:0]  c1, c2, lrd;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ilen_pc_seq #(.XLEN(XLEN), .RESET_PC(RPC)) i_ilen_pc_seq (
    .clk_i(clk), .rst_ni(rst_n), .c_en_i(c_en),
    .hw_valid_i(hv), .hw_data_i(hd), .hw_ready_o(hr),
    .jump_valid_i(jv), .jump_target_i(jt), .jump_rd_i(jrd),
    .insn_valid_o(iv), .insn_o(insn), .insn_c_o(ic), .insn_pc_o(ipc),
    .succ_pc_o(spc), .crs1_o(c1), .crs2_o(c2), .illegal_o(ill),
    .misalign_o(mis), .badaddr_o(bad), .link_we_o(lwe), .link_rd_o(lrd),
    .link_data_o(ldat));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] h);
    @(negedge clk); hv = 1'b1; hd = h;
    @(posedge clk); #1; hv = 1'b0;
  endtask

  task automatic jump(input logic [31:0] t, input logic [4:0] rd);
    @(negedge clk); jv = 1'b1; jt = t; jrd = rd;
    @(posedge clk); #1; jv = 1'b0;
  endtask

  task automatic idle1();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk(iv == 0, "R8 valid", 32'(iv), 0);
    chk(hr == 1, "R8 ready", 32'(hr), 1);
    chk(!ill && !mis && !lwe, "R8 flags", {ill, mis, lwe}, 0);
  endtask

  task automatic t_short();
    c_en = 1'b1;
    push(16'h4501);
    chk(iv && ic, "R1 valid/c", {iv, ic}, 2'b11);
    chk(insn == 32'h0000_4501, "R1 insn", insn, 32'h4501);
    chk(ipc == RPC, "R8 first pc", ipc, RPC);
    chk(spc == RPC + 2, "R1 succ", spc, RPC + 2);
    chk(c1 == 5'd8 + 5'((16'h4501 >> 7) & 7), "R7 crs1", c1, 5'd8 + 5'((16'h4501 >> 7) & 7));
    chk(c2 == 5'd8 + 5'((16'h4501 >> 2) & 7), "R7 crs2", c2, 5'd8 + 5'((16'h4501 >> 2) & 7));
    chk(ill == 0, "R3 legal short", 32'(ill), 0);
    push(16'h1f9d);
    chk(c1 == 5'd8 + 5'((16'h1f9d >> 7) & 7), "R7 crs1 b", c1, 5'd8 + 5'((16'h1f9d >> 7) & 7));
    chk(c2 == 5'd8 + 5'((16'h1f9d >> 2) & 7), "R7 crs2 b", c2, 5'd8 + 5'((16'h1f9d >> 2) & 7));
    chk(ipc == RPC + 2, "R1 pc b", ipc, RPC + 2);
    idle1();
    chk(iv == 0, "R10 valid pulse", 32'(iv), 0);
  endtask

  task automatic t_long();
    push(16'h0093);
    chk(iv == 0, "R2 hold first half", 32'(iv), 0);
    push(16'h0010);
    chk(iv && !ic, "R2 valid/c", {iv, ic}, 2'b10);
    chk(insn == 32'h0010_0093, "R2 insn", insn, 32'h0010_0093);
    chk(ipc == 32'h104, "R2 pc", ipc, 32'h104);
    chk(spc == 32'h108, "R2 succ", spc, 32'h108);
  endtask

  task automatic t_illegal();
    c_en = 1'b0;
    push(16'h0000);
    chk(ill && iv, "R3 illegal short", {ill, iv}, 2'b11);
    chk(spc == 32'h10a, "R1 succ illegal", spc, 32'h10a);
    idle1();
    chk(ill == 0, "R10 illegal pulse", 32'(ill), 0);
    push(16'h0013); push(16'h0000);
    chk(iv && !ill, "R3 long legal", {iv, ill}, 2'b10);
    chk(spc == 32'h10e, "R2 succ", spc, 32'h10e);
  endtask

  task automatic t_link();
    jump(32'h200, 5'd5);
    chk(lwe == 1 && lrd == 5'd5, "R6 link we/rd", {lwe, lrd}, {1'b1, 5'd5});
    chk(ldat == 32'h10e, "R6 link data", ldat, 32'h10e);
    chk(mis == 0, "R4 aligned no fault", 32'(mis), 0);
    idle1();
    chk(lwe == 0, "R10 link pulse", 32'(lwe), 0);
    push(16'h0013); push(16'h0000);
    chk(ipc == 32'h200, "R6 redirect pc", ipc, 32'h200);
    jump(32'h300, 5'd0);
    chk(lwe == 0, "R6 rd zero", 32'(lwe), 0);
    push(16'h0013); push(16'h0000);
    chk(ipc == 32'h300 && spc == 32'h304, "R6 pc after rd0", ipc, 32'h300);
  endtask

  task automatic t_misalign();
    c_en = 1'b0;
    jump(32'h402, 5'd3);
    chk(mis == 1, "R4 misaligned", 32'(mis), 1);
    chk(bad == 32'h300, "R5 badaddr", bad, 32'h300);
    chk(lwe == 0, "R6 no link on fault", 32'(lwe), 0);
    idle1();
    chk(mis == 0, "R10 misalign pulse", 32'(mis), 0);
    push(16'h0013); push(16'h0000);
    chk(ipc == 32'h304, "R5 no redirect", ipc, 32'h304);
  endtask

  task automatic t_cen_targets();
    c_en = 1'b1;
    jump(32'h502, 5'd0);
    chk(mis == 0, "R4 half aligned ok", 32'(mis), 0);
    push(16'h4501);
    chk(ipc == 32'h502, "R4 pc half aligned", ipc, 32'h502);
    jump(32'h601, 5'd0);
    chk(mis == 0, "R4 bit0 no fault", 32'(mis), 0);
    push(16'h4501);
    chk(ipc == 32'h600, "R4 bit0 dropped", ipc, 32'h600);
  endtask

  task automatic t_flush();
    push(16'h0093);
    jump(32'h700, 5'd0);
    push(16'h4501);
    chk(iv && ic, "R9 half dropped", {iv, ic}, 2'b11);
    chk(ipc == 32'h700 && insn == 32'h4501, "R9 resume pc", ipc, 32'h700);
  endtask

  task automatic t_collide();
    @(negedge clk); jv = 1'b1; jt = 32'h800; jrd = 5'd0; hv = 1'b1; hd = 16'h4501;
    #1;
    chk(hr == 0, "R9 ready low", 32'(hr), 0);
    @(posedge clk); #1; jv = 1'b0; hv = 1'b0;
    chk(iv == 0, "R9 not consumed", 32'(iv), 0);
    push(16'h0001);
    chk(ipc == 32'h800 && insn == 32'h0001, "R9 next half", insn, 32'h0001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_short();
    t_long();
    t_illegal();
    t_link();
    t_misalign();
    t_cen_targets();
    t_flush();
    t_collide();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule